// File: doc/BRIEF.md
# Colour-Expansion Write Unit

This unit turns one CPU byte write into a burst of destination pixels for a frame buffer. Each of the eight bits of the written byte selects the colour of one pixel. The bits are taken from the most significant down. A set bit paints the foreground colour. A clear bit either paints the background colour (fill mode) or leaves the destination pixel alone (transparent mode). Pixels are one byte or two bytes wide.

The whole expansion leaves the unit as one wide memory write, one cycle after the request. The write carries a per-byte enable mask, so transparent pixels become holes in the mask while the pixels after them keep their positions. The unit also reports the lowest and highest byte address of the touched span, so that a dirty-tracking block can mark them. A request in any other write mode is not expanded; it only raises a pass-through flag, so the surrounding logic can route it to another path.

Top module: `cexp_unit`

## Requirements
- R1: `wr_mode` value 4 selects transparent expansion and value 5 selects fill expansion. Any other mode value with `wr_valid` high raises `byp_valid` for exactly one cycle, one clock later, with `exp_we` low in that cycle.
- R2: A request in mode 4 or 5 produces `exp_we` high exactly one clock after the request is sampled. `exp_addr` equals `wr_base` in that cycle.
- R3: Bit 7 of `wr_bits` governs pixel 0, which is the lowest byte lane. Bit 7-k governs pixel k.
- R4: A set bit writes the foreground colour. With `wr_wide` high, pixel k fills lanes 2k (`fg_lo`) and 2k+1 (`fg_hi`), and both of those enables are equal. With `wr_wide` low, pixel k fills lane k with `fg_lo`.
- R5: In mode 5 a clear bit writes the background colour (`bg_lo` and `bg_hi`, laid out the same way as in R4). Every lane of the span is enabled.
- R6: In mode 4 a clear bit drives the pixel's lane enables low and its data lanes to zero. Later pixels keep their lanes. A byte of all zeros still gives `exp_we` high, with an all-zero mask.
- R7: With `wr_wide` low, lanes 8 to 15 always have their enables low and their data at zero.
- R8: `dirty_first` equals `wr_base`. `dirty_last` equals `wr_base`+7 for 1-byte pixels and `wr_base`+15 for 2-byte pixels. Both are taken modulo 2^ADDR_W.
- R9: While reset is held and after it is released, `exp_we`, `byp_valid`, `exp_be` and `exp_data` are zero.
- R10: A cycle with `wr_valid` low gives `exp_we` and `byp_valid` low on the next clock. Back-to-back requests each produce their own output on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | CPU byte write request |
| wr_mode | input | 3 | Write mode of the request |
| wr_wide | input | 1 | 1: two bytes per pixel, 0: one byte per pixel |
| wr_base | input | ADDR_W | Byte address of pixel 0 |
| wr_bits | input | NPIX | Written byte, one bit per pixel |
| fg_lo | input | 8 | Foreground colour, low byte |
| fg_hi | input | 8 | Foreground colour, high byte |
| bg_lo | input | 8 | Background colour, low byte |
| bg_hi | input | 8 | Background colour, high byte |
| exp_we | output | 1 | Expanded memory write strobe |
| exp_addr | output | ADDR_W | Byte address of lane 0 |
| exp_be | output | 2*NPIX | Per-lane byte enables |
| exp_data | output | 16*NPIX | Lane data, lane 0 in the low byte |
| dirty_first | output | ADDR_W | First touched byte address |
| dirty_last | output | ADDR_W | Last touched byte address |
| byp_valid | output | 1 | Request passed through unexpanded |

## Verification
The bench builds the unit with its defaults: eight pixels per write and a 20-bit address. Sixteen lanes therefore cover both the one-byte and the two-byte pixel layouts. The narrow address lets a base a few bytes below 2^20 show the wrap of the last dirty address. Alternating patterns such as A5, 81, 40 and 0F, together with the all-zero byte, show the bit order, the holes left by transparent mode and the paired lanes of wide pixels.

// File: rtl/cexp_pkg.sv
`timescale 1ns/1ps
package cexp_pkg;
  localparam logic [2:0] MODE_TRANSP = 3'd4;
  localparam logic [2:0] MODE_FILL   = 3'd5;

  typedef enum logic [1:0] {ACT_IDLE, ACT_EXPAND, ACT_BYPASS} act_e;

  // bytes covered by one expanded write
  function automatic int unsigned span_bytes(int unsigned npix, logic wide);
    return wide ? 2 * npix : npix;
  endfunction

  // which pixel a byte lane belongs to
  function automatic int unsigned lane_pixel(int unsigned lane, logic wide);
    return wide ? lane / 2 : lane;
  endfunction

  // true when a lane carries the high colour byte
  function automatic logic lane_is_high(int unsigned lane, logic wide);
    return wide && (lane % 2 == 1);
  endfunction
endpackage

// File: rtl/cexp_mode_dec.sv
`timescale 1ns/1ps
module cexp_mode_dec
  import cexp_pkg::*;
(
  input  logic       req,
  input  logic [2:0] mode,
  output act_e       act,
  output logic       fill_bg
);
  logic is_exp;
  assign is_exp  = (mode == MODE_TRANSP) || (mode == MODE_FILL);
  assign fill_bg = (mode == MODE_FILL);

  always_comb begin
    if (!req)        act = ACT_IDLE;
    else if (is_exp) act = ACT_EXPAND;
    else             act = ACT_BYPASS;
  end
endmodule

// File: rtl/cexp_lane.sv
`timescale 1ns/1ps
module cexp_lane
  import cexp_pkg::*;
#(
  parameter int LANE = 0,
  parameter int NPIX = 8
) (
  input  logic [NPIX-1:0] bits,
  input  logic            wide,
  input  logic            fill_bg,
  input  logic [7:0]      fg_lo,
  input  logic [7:0]      fg_hi,
  input  logic [7:0]      bg_lo,
  input  logic [7:0]      bg_hi,
  output logic            en,
  output logic [7:0]      byte_o
);
  localparam bit NARROW_OK = (LANE < NPIX);
  localparam int IDX_N     = NARROW_OK ? (NPIX - 1 - LANE) : 0;
  localparam int IDX_W     = NPIX - 1 - (LANE / 2);

  logic in_span, pix_bit, hi_sel;
  logic [7:0] fg_b, bg_b;

  assign in_span = wide | NARROW_OK;
  assign pix_bit = wide ? bits[IDX_W] : (NARROW_OK ? bits[IDX_N] : 1'b0);
  assign hi_sel  = lane_is_high(LANE, wide);
  assign fg_b    = hi_sel ? fg_hi : fg_lo;
  assign bg_b    = hi_sel ? bg_hi : bg_lo;

  always_comb begin
    en     = in_span & (pix_bit | fill_bg);
    byte_o = 8'h00;
    if (in_span) begin
      if (pix_bit)      byte_o = fg_b;
      else if (fill_bg) byte_o = bg_b;
    end
  end
endmodule

// File: rtl/cexp_span.sv
`timescale 1ns/1ps
module cexp_span
  import cexp_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int NPIX   = 8
) (
  input  logic [ADDR_W-1:0] base,
  input  logic              wide,
  output logic [ADDR_W-1:0] first,
  output logic [ADDR_W-1:0] last
);
  logic [ADDR_W-1:0] extent;
  assign extent = ADDR_W'(span_bytes(NPIX, wide) - 1);
  assign first  = base;
  assign last   = base + extent;
endmodule

// File: rtl/cexp_unit.sv
`timescale 1ns/1ps
module cexp_unit
  import cexp_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int NPIX   = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_valid,
  input  logic [2:0]            wr_mode,
  input  logic                  wr_wide,
  input  logic [ADDR_W-1:0]     wr_base,
  input  logic [NPIX-1:0]       wr_bits,
  input  logic [7:0]            fg_lo,
  input  logic [7:0]            fg_hi,
  input  logic [7:0]            bg_lo,
  input  logic [7:0]            bg_hi,
  output logic                  exp_we,
  output logic [ADDR_W-1:0]     exp_addr,
  output logic [2*NPIX-1:0]     exp_be,
  output logic [16*NPIX-1:0]    exp_data,
  output logic [ADDR_W-1:0]     dirty_first,
  output logic [ADDR_W-1:0]     dirty_last,
  output logic                  byp_valid
);
  localparam int LANES = 2 * NPIX;
  localparam int DW    = 8 * LANES;

  act_e              act;
  logic              fill_bg;
  logic [LANES-1:0]  lane_en;
  logic [DW-1:0]     lane_data;
  logic [ADDR_W-1:0] span_first, span_last;
  logic              wide_q, fill_q;

  cexp_mode_dec u_dec (
    .req     (wr_valid),
    .mode    (wr_mode),
    .act     (act),
    .fill_bg (fill_bg)
  );

  for (genvar gl = 0; gl < LANES; gl++) begin : g_lane
    cexp_lane #(.LANE(gl), .NPIX(NPIX)) u_lane (
      .bits    (wr_bits),
      .wide    (wr_wide),
      .fill_bg (fill_bg),
      .fg_lo   (fg_lo),
      .fg_hi   (fg_hi),
      .bg_lo   (bg_lo),
      .bg_hi   (bg_hi),
      .en      (lane_en[gl]),
      .byte_o  (lane_data[8*gl +: 8])
    );
  end

  cexp_span #(.ADDR_W(ADDR_W), .NPIX(NPIX)) u_span (
    .base  (wr_base),
    .wide  (wr_wide),
    .first (span_first),
    .last  (span_last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exp_we      <= 1'b0;
      byp_valid   <= 1'b0;
      exp_addr    <= '0;
      exp_be      <= '0;
      exp_data    <= '0;
      dirty_first <= '0;
      dirty_last  <= '0;
      wide_q      <= 1'b0;
      fill_q      <= 1'b0;
    end else begin
      exp_we    <= (act == ACT_EXPAND);
      byp_valid <= (act == ACT_BYPASS);
      if (act == ACT_EXPAND) begin
        exp_addr    <= wr_base;
        exp_be      <= lane_en;
        exp_data    <= lane_data;
        dirty_first <= span_first;
        dirty_last  <= span_last;
        wide_q      <= wr_wide;
        fill_q      <= fill_bg;
      end else begin
        exp_be   <= '0;
        exp_data <= '0;
      end
    end
  end

  // ---------------- assertions ----------------
  assert_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(exp_we && byp_valid));

  assert_bypass_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_mode != 3'd4 && wr_mode != 3'd5) |=> (byp_valid && !exp_we));

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && (wr_mode == 3'd4 || wr_mode == 3'd5)) |=> exp_we);

  assert_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    exp_we |-> (exp_addr == dirty_first));

  assert_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (exp_we && fill_q) |-> ($countones(exp_be) == (wide_q ? LANES : NPIX)));

  assert_narrow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (exp_we && !wide_q) |-> (exp_be[LANES-1:NPIX] == '0));

  assert_span_R8: assert property (@(posedge clk) disable iff (!rst_n)
    exp_we |-> ((dirty_last - dirty_first) == ADDR_W'(wide_q ? LANES - 1 : NPIX - 1)));

  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |=> (!exp_we && !byp_valid && exp_be == '0));

  for (genvar gp = 0; gp < NPIX; gp++) begin : g_pair_chk
    assert_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (exp_we && wide_q) |-> (exp_be[2*gp] == exp_be[2*gp+1]));
  end
endmodule

// File: tb/sim_cexp_unit.sv
`timescale 1ns/1ps
module sim_cexp_unit;
  localparam int AW = 20;
  localparam int NP = 8;
  localparam int LN = 2 * NP;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic [2:0] wr_mode = 3'd0;
  logic wr_wide = 1'b0;
  logic [AW-1:0] wr_base = '0;
  logic [NP-1:0] wr_bits = '0;
  logic [7:0] fg_lo = 8'h00, fg_hi = 8'h00, bg_lo = 8'h00, bg_hi = 8'h00;
  logic exp_we, byp_valid;
  logic [AW-1:0] exp_addr, dirty_first, dirty_last;
  logic [LN-1:0] exp_be;
  logic [8*LN-1:0] exp_data;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cexp_unit #(.ADDR_W(AW), .NPIX(NP)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_mode(wr_mode),
    .wr_wide(wr_wide), .wr_base(wr_base), .wr_bits(wr_bits),
    .fg_lo(fg_lo), .fg_hi(fg_hi), .bg_lo(bg_lo), .bg_hi(bg_hi),
    .exp_we(exp_we), .exp_addr(exp_addr), .exp_be(exp_be), .exp_data(exp_data),
    .dirty_first(dirty_first), .dirty_last(dirty_last), .byp_valid(byp_valid)
  );

  task automatic check(string req, logic [127:0] got, logic [127:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // reference expansion, pixel-major walk
  task automatic model(input logic [2:0] mode, input logic wide, input logic [7:0] bits,
                       output logic [LN-1:0] be, output logic [8*LN-1:0] data);
    int bp;
    bp = wide ? 2 : 1;
    be = '0;
    data = '0;
    for (int p = 0; p < NP; p++) begin
      logic b;
      b = bits[NP-1-p];
      for (int k = 0; k < bp; k++) begin
        int lane;
        lane = p * bp + k;
        if (b) begin
          be[lane] = 1'b1;
          data[8*lane +: 8] = (k == 1) ? fg_hi : fg_lo;
        end else if (mode == 3'd5) begin
          be[lane] = 1'b1;
          data[8*lane +: 8] = (k == 1) ? bg_hi : bg_lo;
        end
      end
    end
  endtask

  task automatic request(input logic [2:0] mode, input logic wide,
                         input logic [AW-1:0] base, input logic [7:0] bits);
    @(negedge clk);
    wr_valid = 1'b1; wr_mode = mode; wr_wide = wide; wr_base = base; wr_bits = bits;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic expand_case(string req, input logic [2:0] mode, input logic wide,
                             input logic [AW-1:0] base, input logic [7:0] bits);
    logic [LN-1:0] ebe;
    logic [8*LN-1:0] edat;
    logic [AW-1:0] elast;
    model(mode, wide, bits, ebe, edat);
    elast = base + AW'(wide ? 15 : 7);
    request(mode, wide, base, bits);
    check({req, " R2 we"}, 128'(exp_we), 128'(1));
    check({req, " R1 byp"}, 128'(byp_valid), 128'(0));
    check({req, " R2 addr"}, 128'(exp_addr), 128'(base));
    check({req, " be"}, 128'(exp_be), 128'(ebe));
    check({req, " data"}, exp_data, edat);
    check({req, " R8 first"}, 128'(dirty_first), 128'(base));
    check({req, " R8 last"}, 128'(dirty_last), 128'(elast));
  endtask

  task automatic t_reset();
    check("R9 we", 128'(exp_we), 128'(0));
    check("R9 byp", 128'(byp_valid), 128'(0));
    check("R9 be", 128'(exp_be), 128'(0));
    check("R9 data", exp_data, 128'(0));
  endtask

  task automatic t_narrow();
    fg_lo = 8'h3C; fg_hi = 8'hC3; bg_lo = 8'h11; bg_hi = 8'h22;
    expand_case("R3 R5 R7 fill 8bpp A5", 3'd5, 1'b0, 20'h01000, 8'hA5);
    expand_case("R3 R6 R7 transp 8bpp 81", 3'd4, 1'b0, 20'h02008, 8'h81);
  endtask

  task automatic t_wide();
    fg_lo = 8'h5A; fg_hi = 8'hE1; bg_lo = 8'h07; bg_hi = 8'h70;
    expand_case("R4 R6 transp 16bpp 40", 3'd4, 1'b1, 20'h03010, 8'h40);
    expand_case("R4 R5 fill 16bpp 0F", 3'd5, 1'b1, 20'h04020, 8'h0F);
  endtask

  task automatic t_zero_byte();
    expand_case("R6 transp all clear", 3'd4, 1'b1, 20'h05000, 8'h00);
  endtask

  task automatic t_wrap();
    expand_case("R8 wrap 8bpp", 3'd5, 1'b0, 20'hFFFFC, 8'hF0);
    expand_case("R8 top 16bpp", 3'd4, 1'b1, 20'hFFFF0, 8'hFF);
  endtask

  task automatic t_bypass();
    logic [2:0] modes [6] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd6, 3'd7};
    foreach (modes[i]) begin
      request(modes[i], 1'b0, 20'h00100, 8'hFF);
      check("R1 bypass flag", 128'(byp_valid), 128'(1));
      check("R1 bypass no write", 128'(exp_we), 128'(0));
      @(negedge clk);
      check("R1 bypass one cycle", 128'(byp_valid), 128'(0));
    end
  endtask

  task automatic t_idle_b2b();
    logic [LN-1:0] be1, be2;
    logic [8*LN-1:0] d1, d2;
    fg_lo = 8'h99; bg_lo = 8'h44;
    @(negedge clk);
    check("R10 idle we", 128'(exp_we), 128'(0));
    check("R10 idle byp", 128'(byp_valid), 128'(0));
    model(3'd4, 1'b0, 8'hC0, be1, d1);
    model(3'd5, 1'b0, 8'h03, be2, d2);
    wr_valid = 1'b1; wr_mode = 3'd4; wr_wide = 1'b0; wr_base = 20'h00200; wr_bits = 8'hC0;
    @(negedge clk);
    check("R10 b2b first be", 128'(exp_be), 128'(be1));
    check("R10 b2b first data", exp_data, d1);
    wr_mode = 3'd5; wr_base = 20'h00208; wr_bits = 8'h03;
    @(negedge clk);
    wr_valid = 1'b0;
    check("R10 b2b second be", 128'(exp_be), 128'(be2));
    check("R10 b2b second data", exp_data, d2);
    check("R10 b2b second addr", 128'(exp_addr), 128'(20'h00208));
    @(negedge clk);
    check("R10 after b2b we", 128'(exp_we), 128'(0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_narrow();
    t_wide();
    t_zero_byte();
    t_wrap();
    t_bypass();
    t_idle_b2b();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R2 got=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule